// File: doc/BRIEF.md
# Cascadable Eight-Line Priority Interrupt Controller

This block collects eight interrupt request lines, latches their rising edges, resolves them by fixed priority against the requests already being serviced, and raises a single interrupt toward the processor. When the processor acknowledges, the block hands over an 8-bit vector. The vector is formed from a programmed base and the index of the winning line. Software talks to the block through a two-address register port (an even address and an odd address). An ordered series of setup words brings the block into service. Later writes mask lines, end the service of a line, and pick which internal register the even address reads back.

Two instances can be chained. A slave instance drives its interrupt output into one request line of a master instance, so the pair serves fifteen sources. When the master acknowledges a line marked as carrying a slave, it does not supply a vector. It publishes the line number on a cascade identifier bus, and the slave whose programmed identity matches supplies the vector instead. A nesting option lets the master accept a second request from a slave line that is already in service, so that higher-priority slave requests can preempt lower ones.

Top module: `casc_intc`

## Requirements
- R1: After reset the interrupt output is low, vector enable and cascade valid are low, and both addresses read back 0x00.
- R2: An even-address write with bit 4 set begins setup. The next odd writes load, in order: the vector base, taken from data bits 7:3. Then the cascade word, which is skipped when bit 1 of the first word is 1 (single mode). Then the mode word, which is expected only when bit 0 of the first word is 1. After these, odd writes load the mask register. The interrupt output stays low until setup completes.
- R3: A setup-start write at any time clears the mask, the pending register, the in-service register and the read-select (back to pending), and restarts the sequence.
- R4: A rising edge on a request line sets its pending bit, which is visible at the next clock. A line held high does not set the bit again. The bit stays set after the line falls, until the request is acknowledged.
- R5: A line whose mask bit is 1 neither raises the interrupt nor is acknowledged, though its edges still latch. Clearing the mask bit lets the latched request raise the interrupt.
- R6: Line 0 has the highest priority and line 7 the lowest. The vector is the base in bits 7:3 with the line index in bits 2:0.
- R7: The interrupt is raised only when the best unmasked pending line has higher priority than every line set in the in-service register.
- R8: During a one-cycle acknowledge, vec_o and vec_en_o present the winning vector. At the clock edge closing it, that line's pending bit clears and its in-service bit sets. An acknowledge with nothing eligible changes nothing, and vec_en_o stays low.
- R9: With mode-word bit 1 set (automatic end of service), an acknowledge leaves the in-service bit clear.
- R10: An even write with bits 7:5 = 001 and bits 4:3 = 00 clears the highest-priority in-service bit. With bits 7:5 = 011 it clears the in-service bit named by bits 2:0.
- R11: An even write with bit 4 = 0, bit 3 = 1 and bit 1 = 1 selects the even-address read source: bit 0 = 1 selects the in-service register, 0 selects the pending register. The odd address reads the mask.
- R12: In a master (slave_mode_i = 0, cascade mode), the cascade word is a bitmap of slave-carrying lines. Acknowledging such a line raises cas_vld_o with cas_id_o equal to the line index, and vec_en_o stays low.
- R13: In a slave (slave_mode_i = 1, cascade mode), cascade-word bits 2:0 are its identity. It supplies a vector and updates its registers on acknowledge only when cas_vld_i is high and cas_id_i equals that identity.
- R14: With mode-word bit 4 set in a master, a request on a slave-carrying line that is already in service may raise the interrupt again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_i | input | 8 | Request lines, rising-edge sensitive |
| addr_odd_i | input | 1 | Register address: 0 even, 1 odd |
| wr_en_i | input | 1 | Write strobe |
| wr_data_i | input | 8 | Write data |
| rd_data_o | output | 8 | Read data for the selected address |
| ack_i | input | 1 | One-cycle interrupt acknowledge |
| slave_mode_i | input | 1 | 1 makes this instance a cascade slave |
| cas_vld_i | input | 1 | Master is calling a slave on this acknowledge |
| cas_id_i | input | 3 | Slave identity being called |
| irq_o | output | 1 | Interrupt request to the processor or master |
| vec_o | output | 8 | Vector of the current winner |
| vec_en_o | output | 1 | This instance supplies vec_o on this acknowledge |
| cas_vld_o | output | 1 | Acknowledged line carries a slave |
| cas_id_o | output | 3 | Line index published to slaves |

## Verification
A wrong pending or in-service bit shows at the ports in two ways. The interrupt output is high or low on the cycle after the bad update, and the even-address readback disagrees at once. Every idle cycle of the run compares a readback, so a stray bit is exposed within one cycle. A setup-sequence fault misplaces the vector base or the mask, and it surfaces on the first acknowledge or mask read after setup. Cascade faults show during the acknowledge cycle itself, as the wrong instance enabling its vector or the wrong identifier on the cascade bus.

// File: rtl/cic_pkg.sv
package cic_pkg;

    localparam int LINES  = 8;
    localparam int IDX_W  = $clog2(LINES);
    localparam int VEC_W  = 8;
    localparam int BASE_W = VEC_W - IDX_W;

    // first setup word
    localparam int W1_START_BIT  = 4;
    localparam int W1_SINGLE_BIT = 1;
    localparam int W1_MODEW_BIT  = 0;
    // mode word
    localparam int MW_AUTO_BIT   = 1;
    localparam int MW_NEST_BIT   = 4;
    // even-address commands
    localparam int CMD_SEL_BIT   = 3;
    localparam int CMD_RDEN_BIT  = 1;
    localparam int CMD_RDSRC_BIT = 0;
    localparam logic [2:0] EOI_ANY  = 3'b001;
    localparam logic [2:0] EOI_LINE = 3'b011;

    typedef logic [LINES-1:0] line_vec_t;
    typedef logic [IDX_W-1:0] line_idx_t;

    typedef enum logic [2:0] {
        CS_OFF,
        CS_BASE,
        CS_CASC,
        CS_MODE,
        CS_RUN
    } cfg_state_e;

    typedef struct packed {
        logic [BASE_W-1:0] vbase;
        logic              single;
        logic              want_mode;
        line_vec_t         casc_map;
        logic              auto_eoi;
        logic              nested_sp;
    } cfg_t;

    typedef struct packed {
        logic      hit;
        line_idx_t idx;
    } pick_t;

    // lowest index wins
    function automatic pick_t pick_first(line_vec_t v);
        pick_t p;
        p.hit = 1'b0;
        p.idx = '0;
        for (int i = LINES - 1; i >= 0; i--) begin
            if (v[i]) begin
                p.hit = 1'b1;
                p.idx = line_idx_t'(i);
            end
        end
        return p;
    endfunction

    function automatic line_vec_t one_hot(line_idx_t i);
        line_vec_t v;
        v    = '0;
        v[i] = 1'b1;
        return v;
    endfunction

endpackage

// File: rtl/cic_cfg.sv
module cic_cfg
    import cic_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  wr_en,
    input  logic                  addr_odd,
    input  logic [VEC_W-1:0]      wr_data,
    output cfg_state_e            state,
    output logic [BASE_W-1:0]     vbase,
    output logic                  single,
    output line_vec_t             casc_map,
    output logic                  auto_eoi,
    output logic                  nested_sp,
    output line_vec_t             mask,
    output logic                  rd_isr,
    output logic                  init_pulse,
    output logic                  eoi_any,
    output logic                  eoi_line,
    output line_idx_t             eoi_lvl
);

    cfg_t cfg_q;
    logic running;
    logic even_cmd;

    assign running    = (state == CS_RUN);
    assign init_pulse = wr_en && !addr_odd && wr_data[W1_START_BIT];
    assign even_cmd   = wr_en && !addr_odd && !wr_data[W1_START_BIT] && running;
    assign eoi_any    = even_cmd && !wr_data[CMD_SEL_BIT] && (wr_data[7:5] == EOI_ANY);
    assign eoi_line   = even_cmd && !wr_data[CMD_SEL_BIT] && (wr_data[7:5] == EOI_LINE);
    assign eoi_lvl    = wr_data[IDX_W-1:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= CS_OFF;
            cfg_q  <= '0;
            mask   <= '0;
            rd_isr <= 1'b0;
        end else if (init_pulse) begin
            state              <= CS_BASE;
            cfg_q.single       <= wr_data[W1_SINGLE_BIT];
            cfg_q.want_mode    <= wr_data[W1_MODEW_BIT];
            cfg_q.casc_map     <= '0;
            cfg_q.auto_eoi     <= 1'b0;
            cfg_q.nested_sp    <= 1'b0;
            mask               <= '0;
            rd_isr             <= 1'b0;
        end else if (wr_en && addr_odd) begin
            case (state)
                CS_BASE: begin
                    cfg_q.vbase <= wr_data[VEC_W-1:IDX_W];
                    if (!cfg_q.single)
                        state <= CS_CASC;
                    else
                        state <= cfg_q.want_mode ? CS_MODE : CS_RUN;
                end
                CS_CASC: begin
                    cfg_q.casc_map <= wr_data;
                    state          <= cfg_q.want_mode ? CS_MODE : CS_RUN;
                end
                CS_MODE: begin
                    cfg_q.auto_eoi  <= wr_data[MW_AUTO_BIT];
                    cfg_q.nested_sp <= wr_data[MW_NEST_BIT];
                    state           <= CS_RUN;
                end
                CS_RUN:  mask <= wr_data;
                default: ;
            endcase
        end else if (even_cmd && wr_data[CMD_SEL_BIT] && wr_data[CMD_RDEN_BIT]) begin
            rd_isr <= wr_data[CMD_RDSRC_BIT];
        end
    end

    assign vbase     = cfg_q.vbase;
    assign single    = cfg_q.single;
    assign casc_map  = cfg_q.casc_map;
    assign auto_eoi  = cfg_q.auto_eoi;
    assign nested_sp = cfg_q.nested_sp;

    // R3
    init_restart_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !addr_odd && wr_data[W1_START_BIT]) |=> (state == CS_BASE && mask == '0));

    // R2
    mask_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (state != CS_RUN && !(wr_en && !addr_odd && wr_data[W1_START_BIT])) |=> mask == $past(mask));

endmodule

// File: rtl/cic_irr.sv
module cic_irr
    import cic_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      clear,
    input  line_vec_t req_i,
    input  logic      take,
    input  line_idx_t take_idx,
    output line_vec_t irr
);

    line_vec_t prev_q;
    line_vec_t rise;
    line_vec_t drop;

    assign rise = req_i & ~prev_q;
    assign drop = take ? one_hot(take_idx) : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q <= '0;
            irr    <= '0;
        end else if (clear) begin
            prev_q <= req_i;
            irr    <= '0;
        end else begin
            prev_q <= req_i;
            irr    <= (irr & ~drop) | rise;
        end
    end

    // R3
    irr_clear_chk: assert property (@(posedge clk) disable iff (rst)
        clear |=> irr == '0);

    // R4
    edge_latch_chk: assert property (@(posedge clk) disable iff (rst)
        !clear |=> ((irr & $past(req_i & ~prev_q)) == $past(req_i & ~prev_q)));

endmodule

// File: rtl/cic_arb.sv
module cic_arb
    import cic_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  cfg_state_e        state,
    input  logic [BASE_W-1:0] vbase,
    input  logic              single,
    input  line_vec_t         casc_map,
    input  logic              nested_sp,
    input  logic              slave_mode,
    input  line_vec_t         irr,
    input  line_vec_t         mask,
    input  line_vec_t         isr,
    input  logic              ack_i,
    input  logic              cas_vld_i,
    input  line_idx_t         cas_id_i,
    output logic              irq_o,
    output logic              take,
    output line_idx_t         take_idx,
    output logic [VEC_W-1:0]  vec_o,
    output logic              vec_en_o,
    output logic              cas_vld_o,
    output line_idx_t         cas_id_o
);

    pick_t pend;
    pick_t srv;
    logic  casc_line;
    logic  nest_ok;
    logic  allowed;
    logic  chosen;
    logic  as_slave;

    assign pend      = pick_first(irr & ~mask);
    assign srv       = pick_first(isr);
    assign as_slave  = slave_mode && !single;
    assign casc_line = !single && !slave_mode && casc_map[pend.idx];
    assign nest_ok   = nested_sp && casc_line && (srv.idx == pend.idx);
    assign allowed   = pend.hit && (!srv.hit || (pend.idx < srv.idx) || nest_ok);
    assign irq_o     = (state == CS_RUN) && allowed;
    assign chosen    = as_slave ? (cas_vld_i && (cas_id_i == casc_map[IDX_W-1:0])) : 1'b1;
    assign take      = ack_i && irq_o && chosen;
    assign take_idx  = pend.idx;

    assign vec_o     = {vbase, pend.idx};
    assign vec_en_o  = take && !casc_line;
    assign cas_vld_o = take && casc_line;
    assign cas_id_o  = cas_vld_o ? pend.idx : '0;

    // R12
    vec_cas_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(vec_en_o && cas_vld_o));

endmodule

// File: rtl/casc_intc.sv
module casc_intc
    import cic_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [7:0]       req_i,
    input  logic             addr_odd_i,
    input  logic             wr_en_i,
    input  logic [7:0]       wr_data_i,
    output logic [7:0]       rd_data_o,
    input  logic             ack_i,
    input  logic             slave_mode_i,
    input  logic             cas_vld_i,
    input  logic [2:0]       cas_id_i,
    output logic             irq_o,
    output logic [7:0]       vec_o,
    output logic             vec_en_o,
    output logic             cas_vld_o,
    output logic [2:0]       cas_id_o
);

    cfg_state_e        cstate;
    logic [BASE_W-1:0] vbase;
    logic              single;
    line_vec_t         casc_map;
    logic              auto_eoi;
    logic              nested_sp;
    line_vec_t         mask;
    logic              rd_isr;
    logic              init_pulse;
    logic              eoi_any;
    logic              eoi_line;
    line_idx_t         eoi_lvl;
    line_vec_t         irr;
    line_vec_t         isr;
    logic              take;
    line_idx_t         take_idx;

    cic_cfg u_cfg (
        .clk        (clk),
        .rst        (rst),
        .wr_en      (wr_en_i),
        .addr_odd   (addr_odd_i),
        .wr_data    (wr_data_i),
        .state      (cstate),
        .vbase      (vbase),
        .single     (single),
        .casc_map   (casc_map),
        .auto_eoi   (auto_eoi),
        .nested_sp  (nested_sp),
        .mask       (mask),
        .rd_isr     (rd_isr),
        .init_pulse (init_pulse),
        .eoi_any    (eoi_any),
        .eoi_line   (eoi_line),
        .eoi_lvl    (eoi_lvl)
    );

    cic_irr u_irr (
        .clk      (clk),
        .rst      (rst),
        .clear    (init_pulse),
        .req_i    (req_i),
        .take     (take),
        .take_idx (take_idx),
        .irr      (irr)
    );

    cic_arb u_arb (
        .clk        (clk),
        .rst        (rst),
        .state      (cstate),
        .vbase      (vbase),
        .single     (single),
        .casc_map   (casc_map),
        .nested_sp  (nested_sp),
        .slave_mode (slave_mode_i),
        .irr        (irr),
        .mask       (mask),
        .isr        (isr),
        .ack_i      (ack_i),
        .cas_vld_i  (cas_vld_i),
        .cas_id_i   (cas_id_i),
        .irq_o      (irq_o),
        .take       (take),
        .take_idx   (take_idx),
        .vec_o      (vec_o),
        .vec_en_o   (vec_en_o),
        .cas_vld_o  (cas_vld_o),
        .cas_id_o   (cas_id_o)
    );

    // in-service tracking
    pick_t     srv_top;
    line_vec_t set_v;
    line_vec_t clr_v;

    assign srv_top = pick_first(isr);

    always_comb begin
        set_v = '0;
        clr_v = '0;
        if (take && !auto_eoi)
            set_v = one_hot(take_idx);
        if (eoi_any && srv_top.hit)
            clr_v = clr_v | one_hot(srv_top.idx);
        if (eoi_line)
            clr_v = clr_v | one_hot(eoi_lvl);
    end

    always_ff @(posedge clk) begin
        if (rst || init_pulse)
            isr <= '0;
        else
            isr <= (isr | set_v) & ~clr_v;
    end

    assign rd_data_o = addr_odd_i ? mask : (rd_isr ? isr : irr);

    // R8
    isr_set_chk: assert property (@(posedge clk) disable iff (rst)
        (take && !auto_eoi && !eoi_any && !eoi_line && !init_pulse) |=> isr[$past(take_idx)]);

    // R10
    isr_eoi_chk: assert property (@(posedge clk) disable iff (rst)
        (eoi_any && isr != '0 && !take && !init_pulse)
            |=> $countones(isr) == $countones($past(isr)) - 1);

    // R2
    irq_setup_chk: assert property (@(posedge clk) disable iff (rst)
        init_pulse |=> !irq_o);

endmodule

// File: tb/casc_intc_tb.sv
module casc_intc_tb;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic       rst = 1'b1;
    logic [7:0] mreq = '0, sreq = '0, wdata = '0;
    logic       addr_odd = 1'b0, wr_m = 1'b0, wr_s = 1'b0, ack = 1'b0;
    logic       casc_ph = 1'b0;

    logic [7:0] m_bus;
    logic [7:0] m_rd, m_vec, s_rd, s_vec;
    logic       m_irq, m_ven, m_cv, s_irq, s_ven, s_cv;
    logic [2:0] m_cid, s_cid;

    assign m_bus = casc_ph ? {mreq[7:3], s_irq, mreq[1:0]} : mreq;

    casc_intc u_dut (
        .clk(clk), .rst(rst), .req_i(m_bus), .addr_odd_i(addr_odd), .wr_en_i(wr_m),
        .wr_data_i(wdata), .rd_data_o(m_rd), .ack_i(ack), .slave_mode_i(1'b0),
        .cas_vld_i(1'b0), .cas_id_i(3'd0), .irq_o(m_irq), .vec_o(m_vec),
        .vec_en_o(m_ven), .cas_vld_o(m_cv), .cas_id_o(m_cid)
    );

    casc_intc u_slv (
        .clk(clk), .rst(rst), .req_i(sreq), .addr_odd_i(addr_odd), .wr_en_i(wr_s),
        .wr_data_i(wdata), .rd_data_o(s_rd), .ack_i(ack), .slave_mode_i(1'b1),
        .cas_vld_i(m_cv), .cas_id_i(m_cid), .irq_o(s_irq), .vec_o(s_vec),
        .vec_en_o(s_ven), .cas_vld_o(s_cv), .cas_id_o(s_cid)
    );

    int n_chk = 0, n_fail = 0;

    task automatic chk(string tag, logic [7:0] got, logic [7:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %02h expected %02h at %0t", tag, got, exp, $time);
        end
    endtask

    task automatic report();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    // reference state from the requirements
    int         m_st = 0;
    bit         m_single, m_w4, m_aeoi, m_rdisr;
    logic [4:0] m_vb = '0;
    logic [7:0] m_mask = '0, m_irr = '0, m_isr = '0, m_prev = '0;

    function automatic int top_bit(logic [7:0] v);
        for (int i = 0; i < 8; i++) if (v[i]) return i;
        return 8;
    endfunction

    function automatic bit exp_irq();
        int p, s;
        p = top_bit(m_irr & ~m_mask);
        s = top_bit(m_isr);
        return (m_st == 4) && (p < 8) && (p < s);
    endfunction

    // one clock of single-instance stimulus with prediction
    task automatic cyc(string tag, logic [7:0] rq, bit wr, bit odd, logic [7:0] d, bit ak);
        int p, s;
        bit go;
        logic [7:0] rise;
        @(negedge clk);
        chk({tag, " irq"}, {7'd0, m_irq}, {7'd0, exp_irq()});
        mreq = rq; wr_m = wr; addr_odd = odd; wdata = d; ack = ak;
        #1;
        p  = top_bit(m_irr & ~m_mask);
        go = ak && exp_irq();
        if (ak) begin
            chk({tag, " vec_en"}, {7'd0, m_ven}, {7'd0, go});
            if (go) chk({tag, " vec"}, m_vec, {m_vb, p[2:0]});
        end
        if (!wr) chk({tag, " rd"}, m_rd, odd ? m_mask : (m_rdisr ? m_isr : m_irr));
        if (wr && !odd && d[4]) begin
            m_st = 1; m_single = d[1]; m_w4 = d[0]; m_aeoi = 0; m_mask = '0;
            m_rdisr = 0; m_irr = '0; m_isr = '0; m_prev = rq;
        end else begin
            rise = rq & ~m_prev;
            m_prev = rq;
            if (go) begin
                m_irr[p] = 1'b0;
                if (!m_aeoi) m_isr[p] = 1'b1;
            end
            m_irr = m_irr | rise;
            if (wr && odd) begin
                case (m_st)
                    1: begin m_vb = d[7:3]; m_st = m_single ? (m_w4 ? 3 : 4) : 2; end
                    2: m_st = m_w4 ? 3 : 4;
                    3: begin m_aeoi = d[1]; m_st = 4; end
                    4: m_mask = d;
                    default: ;
                endcase
            end
            if (wr && !odd && m_st == 4) begin
                if (d[3]) begin
                    if (d[1]) m_rdisr = d[0];
                end else if (d[7:5] == 3'b001) begin
                    s = top_bit(m_isr);
                    if (s < 8) m_isr[s] = 1'b0;
                end else if (d[7:5] == 3'b011) begin
                    m_isr[d[2:0]] = 1'b0;
                end
            end
        end
        @(posedge clk);
    endtask

    task automatic bstep(logic [7:0] mr, logic [7:0] sr, bit wm, bit ws, bit od, logic [7:0] d);
        @(negedge clk);
        mreq = mr; sreq = sr; wr_m = wm; wr_s = ws; addr_odd = od; wdata = d; ack = 1'b0;
        @(posedge clk);
    endtask

    task automatic back(string tag, bit e_mven, bit e_cv, bit e_sven, logic [7:0] e_vec);
        @(negedge clk);
        wr_m = 0; wr_s = 0; ack = 1'b1;
        #1;
        chk({tag, " master vec_en"}, {7'd0, m_ven}, {7'd0, e_mven});
        chk({tag, " cas_vld"}, {7'd0, m_cv}, {7'd0, e_cv});
        chk({tag, " slave vec_en"}, {7'd0, s_ven}, {7'd0, e_sven});
        if (e_cv)   chk({tag, " cas_id"}, {5'd0, m_cid}, 8'd2);
        if (e_mven) chk({tag, " master vec"}, m_vec, e_vec);
        if (e_sven) chk({tag, " slave vec"}, s_vec, e_vec);
        @(posedge clk);
        @(negedge clk);
        ack = 1'b0;
    endtask

    task automatic idle_b(int n);
        for (int i = 0; i < n; i++) bstep(mreq, sreq, 0, 0, 0, 8'h00);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: run did not finish");
        report();
        $finish;
    end

    initial begin
        logic [7:0] rq;
        int op;
        void'($urandom(32'h1a2b3c4d));
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;

        // R1 reset state
        cyc("R1", 8'h00, 0, 0, 8'h00, 0);
        cyc("R1", 8'h00, 0, 1, 8'h00, 0);
        chk("R1 vec_en", {7'd0, m_ven}, 8'd0);
        chk("R1 cas_vld", {7'd0, m_cv}, 8'd0);

        // R2 ordered setup, single mode with mode word
        cyc("R2", 8'h00, 1, 0, 8'h13, 0);
        cyc("R2", 8'h08, 0, 0, 8'h00, 0);
        cyc("R2", 8'h08, 1, 1, 8'h40, 0);
        cyc("R2", 8'h08, 0, 0, 8'h00, 0);
        cyc("R2", 8'h08, 1, 1, 8'h00, 0);
        cyc("R4", 8'h08, 0, 0, 8'h00, 0);
        cyc("R6", 8'h08, 0, 0, 8'h00, 1);      // R8 vector 0x43
        cyc("R4", 8'h08, 0, 0, 8'h00, 0);      // held high: no relatch
        cyc("R11", 8'h08, 1, 0, 8'h0B, 0);
        cyc("R11", 8'h08, 0, 0, 8'h00, 0);
        cyc("R7", 8'h28, 0, 0, 8'h00, 0);
        cyc("R7", 8'h28, 0, 0, 8'h00, 0);      // line 5 blocked by line 3
        cyc("R7", 8'h2A, 0, 0, 8'h00, 0);
        cyc("R7", 8'h2A, 0, 0, 8'h00, 1);      // nested line 1
        cyc("R10", 8'h2A, 1, 0, 8'h20, 0);
        cyc("R10", 8'h2A, 0, 0, 8'h00, 0);
        cyc("R10", 8'h2A, 1, 0, 8'h63, 0);
        cyc("R10", 8'h2A, 0, 0, 8'h00, 0);
        cyc("R5", 8'h2A, 1, 1, 8'h20, 0);
        cyc("R5", 8'h2A, 0, 1, 8'h00, 0);
        cyc("R5", 8'h2A, 0, 0, 8'h00, 1);      // masked: nothing taken
        cyc("R5", 8'h2A, 1, 1, 8'h00, 0);
        cyc("R5", 8'h2A, 0, 0, 8'h00, 1);
        cyc("R10", 8'h00, 1, 0, 8'h20, 0);
        cyc("R6", 8'h84, 0, 0, 8'h00, 0);
        cyc("R6", 8'h84, 0, 0, 8'h00, 1);      // line 2 beats line 7
        cyc("R3", 8'h84, 1, 0, 8'h13, 0);
        cyc("R3", 8'h84, 0, 0, 8'h00, 0);
        cyc("R3", 8'h84, 0, 1, 8'h00, 0);
        cyc("R9", 8'h84, 1, 1, 8'h60, 0);
        cyc("R9", 8'hC4, 1, 1, 8'h02, 0);
        cyc("R9", 8'hC4, 0, 0, 8'h00, 1);
        cyc("R9", 8'hC4, 1, 0, 8'h0B, 0);
        cyc("R9", 8'hC4, 0, 0, 8'h00, 0);

        // R2 setup without mode word, then random traffic
        cyc("R2", 8'h00, 1, 0, 8'h12, 0);
        cyc("R2", 8'h00, 1, 1, 8'h88, 0);
        rq = 8'h00;
        for (int i = 0; i < 600; i++) begin
            rq = rq ^ (8'($urandom) & 8'($urandom) & 8'($urandom));
            op = $urandom % 10;
            case (op)
                0, 1, 2: cyc("R8", rq, 0, 0, 8'h00, 1);
                3: cyc("R5", rq, 1, 1, 8'($urandom) & 8'($urandom), 0);
                4: cyc("R10", rq, 1, 0, 8'h20, 0);
                5: cyc("R10", rq, 1, 0, 8'h60 | 8'($urandom % 8), 0);
                6: cyc("R11", rq, 1, 0, 8'h0A | 8'($urandom % 2), 0);
                default: cyc("R7", rq, 0, op[0], 8'h00, 0);
            endcase
        end
        @(negedge clk);
        wr_m = 0; ack = 0; mreq = '0;

        // cascade: R12 R13 R14
        casc_ph = 1'b1;
        bstep(8'h00, 8'h00, 1, 1, 0, 8'h11);
        bstep(8'h00, 8'h00, 1, 0, 1, 8'h50);
        bstep(8'h00, 8'h00, 1, 0, 1, 8'h04);
        bstep(8'h00, 8'h00, 1, 0, 1, 8'h10);
        bstep(8'h00, 8'h00, 0, 1, 1, 8'h70);
        bstep(8'h00, 8'h00, 0, 1, 1, 8'h02);
        bstep(8'h00, 8'h00, 0, 1, 1, 8'h00);
        bstep(8'h10, 8'h40, 0, 0, 0, 8'h00);
        idle_b(3);
        chk("R12 master irq", {7'd0, m_irq}, 8'd1);
        back("R12", 0, 1, 1, 8'h76);
        idle_b(2);
        chk("R7 line 4 blocked", {7'd0, m_irq}, 8'd0);
        bstep(8'h10, 8'h42, 0, 0, 0, 8'h00);
        idle_b(3);
        chk("R14 slave irq", {7'd0, s_irq}, 8'd1);
        chk("R14 master irq", {7'd0, m_irq}, 8'd1);
        back("R14", 0, 1, 1, 8'h71);
        idle_b(2);
        chk("R7 master irq", {7'd0, m_irq}, 8'd0);
        bstep(8'h10, 8'h42, 0, 1, 0, 8'h20);
        bstep(8'h10, 8'h42, 0, 1, 0, 8'h20);
        bstep(8'h10, 8'h42, 1, 0, 0, 8'h20);
        idle_b(2);
        chk("R10 master irq", {7'd0, m_irq}, 8'd1);
        back("R13", 1, 0, 0, 8'h54);
        bstep(8'h10, 8'h42, 0, 1, 0, 8'h0B);
        @(negedge clk);
        addr_odd = 1'b0;
        #1;
        chk("R13 slave isr", s_rd, 8'h00);
        chk("R13 slave cas_vld", {7'd0, s_cv}, 8'd0);
        chk("R13 slave cas_id", {5'd0, s_cid}, 8'd0);

        report();
        $finish;
    end

endmodule